// File: doc/BRIEF.md
# Debug Serial Command Port

This block is the target end of a three-wire debug link. An external host drives a serial clock and a data line and listens on a return data line. The core does not clock anything with the host's serial clock: both host inputs pass through synchronizer flops, and the clock level is only taken as changed once the same new level has been seen on two core clock edges in a row. Each such validated rising edge is the single moment at which a received bit is taken in and the return line moves on to its next bit.

Received bits are gathered into fixed 17-bit packets, first bit as most significant. The first bit carries a control or status flag and the other sixteen carry payload. When the last bit of a packet arrives, the whole word is shown to the core side with a one-cycle strobe. For the return direction the core hands over a 17-bit response word. That word goes out, most significant bit first, during the next packet that starts. If no response is waiting, the port sends a "not ready" word instead: a 1 followed by sixteen zeros.

The receive side is a state machine with three states. RX_IDLE moves to RX_SHIFT on the first validated edge of a packet. RX_SHIFT moves to RX_DONE on the edge that brings in the last bit. RX_DONE always returns to RX_IDLE after one cycle. The transmit side has two states. TX_EMPTY moves to TX_PENDING when a response is loaded. TX_PENDING moves back to TX_EMPTY when a packet starts and takes the held word, unless a new load arrives in that same cycle. The clock filter has two states. FLT_LOW moves to FLT_HIGH on two agreeing high samples, and this move is the validated rising edge. FLT_HIGH moves to FLT_LOW on two agreeing low samples.

Top module: `dbg_serial_port`

## Requirements
- R1: The serial clock counts as risen only after its synchronized level reads high on two consecutive core clock edges. A high pulse on `sclk_in` that lasts a single core cycle receives no bit and moves no output.
- R2: `sdi_in` is taken on each validated rising edge. The 17 bits of a packet fill `rx_word` from bit 16 down to bit 0, so the first bit received lands in bit 16, the flag position.
- R3: `rx_valid` is high for exactly one core cycle per packet. It rises at the fourth core clock rising edge after `sclk_in` goes high for the packet's last bit (with `sclk_in` changed between core edges). `rx_word` holds the packet from that cycle onward.
- R4: `sdo_out` comes from a flop and changes only at the core edge that acts on a validated rising serial clock edge. It stays constant through the whole low phase of the serial clock.
- R5: A word given on `tx_word` with a one-cycle `tx_load` pulse, while no packet is in progress, goes out on `sdo_out` during the next packet, bit 16 first. Bit 16-k appears after the packet's k-th validated rising edge, counting from k = 0.
- R6: When a packet starts with no response waiting, the port sends the not-ready word: a 1 as the first bit, then sixteen 0s. After a response has been sent, the following packet sends the not-ready word again.
- R7: A second `tx_load` before the response has been sent replaces the held word, so the last word loaded is the one sent.
- R8: While `rst` is high at a core clock edge, the port clears itself. The bit count returns to zero, any partial packet is dropped, any waiting response is dropped, `rx_valid` is 0 and `sdo_out` is 0.
- R9: The bit count returns to zero after every complete packet. Packets sent back to back are each decoded on their own 17-bit boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk_in | input | 1 | Serial clock from the host, asynchronous |
| sdi_in | input | 1 | Serial data from the host, asynchronous |
| sdo_out | output | 1 | Registered serial data to the host |
| tx_load | input | 1 | One-cycle strobe that takes `tx_word` as the next response |
| tx_word | input | 17 | Response word, bit 16 sent first |
| rx_valid | output | 1 | One-cycle strobe: a whole packet has arrived |
| rx_word | output | 17 | Last complete packet received, bit 16 the first bit |

## Verification
Every result is due four core rising edges after `sclk_in` goes high. Two edges are spent in the synchronizer, one more gives the second agreeing sample, and at the fourth the filter, receiver and return flop all act together. The bench drives the serial lines on falling core edges and holds each serial clock phase for four core cycles. It reads `sdo_out` and `rx_valid` on the falling edge right after that fourth rising edge. It reads `sdo_out` a second time at the end of each low phase to confirm nothing moved. The strobe is checked again one cycle later to confirm it has dropped.

// File: rtl/dsp_pkg.sv
`timescale 1ns/1ps
package dsp_pkg;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_SHIFT,
        RX_DONE
    } rx_state_e;

    typedef enum logic {
        TX_EMPTY,
        TX_PENDING
    } tx_state_e;

    typedef enum logic {
        FLT_LOW,
        FLT_HIGH
    } flt_state_e;

endpackage

// File: rtl/dsp_sync_chain.sv
`timescale 1ns/1ps
module dsp_sync_chain #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d_async;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d_async};
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/dsp_edge_filter.sv
`timescale 1ns/1ps
module dsp_edge_filter
    import dsp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic lvl_sync,
    input  logic dat_sync,
    output logic bit_rise,
    output logic bit_data
);

    flt_state_e state_q, state_d;
    logic       lvl_prev;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= FLT_LOW;
            lvl_prev <= 1'b0;
        end else begin
            state_q  <= state_d;
            lvl_prev <= lvl_sync;
        end
    end

    // next state: two agreeing samples are needed to change level
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLT_LOW:  if (lvl_sync && lvl_prev)   state_d = FLT_HIGH;
            FLT_HIGH: if (!lvl_sync && !lvl_prev) state_d = FLT_LOW;
            default:  state_d = FLT_LOW;
        endcase
    end

    // outputs
    always_comb begin
        bit_rise = (state_q == FLT_LOW) && lvl_sync && lvl_prev;
        bit_data = dat_sync;
    end

    // R1: a validated edge never repeats on the next cycle
    p_rise_gap_r1: assert property (@(posedge clk) disable iff (rst)
        bit_rise |=> !bit_rise);

    // R1: the synchronized level was already high one cycle earlier
    p_rise_agreed_r1: assert property (@(posedge clk) disable iff (rst)
        bit_rise |-> $past(lvl_sync));

endmodule

// File: rtl/dsp_rx_fsm.sv
`timescale 1ns/1ps
module dsp_rx_fsm
    import dsp_pkg::*;
#(
    parameter int PKT_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_rise,
    input  logic             bit_data,
    output logic             pkt_start,
    output logic             rx_valid,
    output logic [PKT_W-1:0] rx_word
);

    localparam int CNT_W = $clog2(PKT_W);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(PKT_W - 1);

    rx_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [PKT_W-1:0] shreg_q;
    logic             last_bit;

    assign last_bit = bit_rise && (cnt_q == LAST_IDX);

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= RX_IDLE;
        else     state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:  if (bit_rise) state_d = RX_SHIFT;
            RX_SHIFT: if (last_bit) state_d = RX_DONE;
            RX_DONE:  state_d = RX_IDLE;
            default:  state_d = RX_IDLE;
        endcase
    end

    // datapath: bit count, shifter and captured word
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            shreg_q <= '0;
            rx_word <= '0;
        end else if (bit_rise && (state_q != RX_DONE)) begin
            shreg_q <= {shreg_q[PKT_W-2:0], bit_data};
            if (last_bit) begin
                cnt_q   <= '0;
                rx_word <= {shreg_q[PKT_W-2:0], bit_data};
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        pkt_start = bit_rise && (state_q == RX_IDLE);
        rx_valid  = (state_q == RX_DONE);
    end

    // R3: the strobe lasts exactly one cycle
    p_valid_single_r3: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R3: the strobe always follows a validated edge
    p_valid_after_rise_r3: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(bit_rise));

    // R9: the bit count never passes the last bit index
    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST_IDX);

    // R9: after the strobe the count is back at zero
    p_cnt_wrap_r9: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> (cnt_q == '0));

endmodule

// File: rtl/dsp_tx_fsm.sv
`timescale 1ns/1ps
module dsp_tx_fsm
    import dsp_pkg::*;
#(
    parameter int PKT_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_rise,
    input  logic             pkt_start,
    input  logic             tx_load,
    input  logic [PKT_W-1:0] tx_word,
    output logic             sdo_q
);

    localparam logic [PKT_W-1:0] NOT_READY = {1'b1, {(PKT_W-1){1'b0}}};

    tx_state_e        state_q, state_d;
    logic [PKT_W-1:0] hold_q;
    logic [PKT_W-1:0] shreg_q;
    logic [PKT_W-1:0] frame;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= TX_EMPTY;
        else     state_q <= state_d;
    end

    // next state: a fresh load wins over the hand-off at packet start
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_EMPTY:   if (tx_load) state_d = TX_PENDING;
            TX_PENDING: if (!tx_load && pkt_start) state_d = TX_EMPTY;
            default:    state_d = TX_EMPTY;
        endcase
    end

    assign frame = (state_q == TX_PENDING) ? hold_q : NOT_READY;

    // holding register
    always_ff @(posedge clk) begin
        if (rst)          hold_q <= '0;
        else if (tx_load) hold_q <= tx_word;
    end

    // output shifter and registered serial output
    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q <= '0;
            sdo_q   <= 1'b0;
        end else if (pkt_start) begin
            sdo_q   <= frame[PKT_W-1];
            shreg_q <= {frame[PKT_W-2:0], 1'b0};
        end else if (bit_rise) begin
            sdo_q   <= shreg_q[PKT_W-1];
            shreg_q <= {shreg_q[PKT_W-2:0], 1'b0};
        end
    end

    // R4: the serial output holds between validated edges
    p_sdo_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !bit_rise |=> $stable(sdo_q));

    // R6: a packet with nothing waiting opens with the flag set
    p_not_ready_flag_r6: assert property (@(posedge clk) disable iff (rst)
        (pkt_start && (state_q == TX_EMPTY)) |=> sdo_q);

    // R5: a waiting response is consumed by the packet that starts
    p_pending_used_r5: assert property (@(posedge clk) disable iff (rst)
        (pkt_start && (state_q == TX_PENDING) && !tx_load) |=> (state_q == TX_EMPTY));

    // R7: any load leaves a response waiting
    p_load_pends_r7: assert property (@(posedge clk) disable iff (rst)
        tx_load |=> (state_q == TX_PENDING));

endmodule

// File: rtl/dbg_serial_port.sv
`timescale 1ns/1ps
module dbg_serial_port #(
    parameter int PKT_W       = 17,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sclk_in,
    input  logic             sdi_in,
    output logic             sdo_out,
    input  logic             tx_load,
    input  logic [PKT_W-1:0] tx_word,
    output logic             rx_valid,
    output logic [PKT_W-1:0] rx_word
);

    logic sclk_s;
    logic sdi_s;
    logic bit_rise;
    logic bit_data;
    logic pkt_start;

    dsp_sync_chain #(.STAGES(SYNC_STAGES)) i_sync_clk (
        .clk     (clk),
        .rst     (rst),
        .d_async (sclk_in),
        .q_sync  (sclk_s)
    );

    dsp_sync_chain #(.STAGES(SYNC_STAGES)) i_sync_dat (
        .clk     (clk),
        .rst     (rst),
        .d_async (sdi_in),
        .q_sync  (sdi_s)
    );

    dsp_edge_filter i_filter (
        .clk      (clk),
        .rst      (rst),
        .lvl_sync (sclk_s),
        .dat_sync (sdi_s),
        .bit_rise (bit_rise),
        .bit_data (bit_data)
    );

    dsp_rx_fsm #(.PKT_W(PKT_W)) i_rx (
        .clk       (clk),
        .rst       (rst),
        .bit_rise  (bit_rise),
        .bit_data  (bit_data),
        .pkt_start (pkt_start),
        .rx_valid  (rx_valid),
        .rx_word   (rx_word)
    );

    dsp_tx_fsm #(.PKT_W(PKT_W)) i_tx (
        .clk       (clk),
        .rst       (rst),
        .bit_rise  (bit_rise),
        .pkt_start (pkt_start),
        .tx_load   (tx_load),
        .tx_word   (tx_word),
        .sdo_q     (sdo_out)
    );

    // R8: the cycle after reset shows the cleared outputs
    p_reset_clear_r8: assert property (@(posedge clk)
        rst |=> (!rx_valid && !sdo_out));

endmodule

// File: tb/test_dbg_serial_port.sv
`timescale 1ns/1ps
module test_dbg_serial_port;

    localparam int W = 17;
    localparam logic [W-1:0] NRDY = 17'h10000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sclk_in = 1'b0;
    logic         sdi_in = 1'b0;
    logic         sdo_out;
    logic         tx_load = 1'b0;
    logic [W-1:0] tx_word = '0;
    logic         rx_valid;
    logic [W-1:0] rx_word;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    dbg_serial_port i_dbg_serial_port (
        .clk      (clk),
        .rst      (rst),
        .sclk_in  (sclk_in),
        .sdi_in   (sdi_in),
        .sdo_out  (sdo_out),
        .tx_load  (tx_load),
        .tx_word  (tx_word),
        .rx_valid (rx_valid),
        .rx_word  (rx_word)
    );

    // vector: {load flag, response word, packet sent by host}
    localparam int NV = 6;
    localparam logic [2*W:0] VEC [NV] = '{
        {1'b0, 17'h00000, 17'h1A5C3},
        {1'b1, 17'h0BEEF, 17'h00001},
        {1'b0, 17'h00000, 17'h10000},
        {1'b1, 17'h1FFFF, 17'h0FFFF},
        {1'b1, 17'h00001, 17'h15555},
        {1'b0, 17'h00000, 17'h0AAAA}
    };

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load_resp(input logic [W-1:0] w);
        @(negedge clk);
        tx_word = w;
        tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
    endtask

    // Sends nbits of pkt (from bit 16 down). Returns what sdo_out showed.
    task automatic send_bits(input logic [W-1:0] pkt, input int nbits,
                             output logic [W-1:0] seen);
        logic prev;
        seen = '0;
        prev = sdo_out;
        for (int k = 0; k < nbits; k++) begin
            sclk_in = 1'b0;
            sdi_in  = pkt[W-1-k];
            repeat (4) @(negedge clk);
            if (k > 0)
                chk(sdo_out == prev, "R4 sdo held in low phase", W'(sdo_out), W'(prev));
            sclk_in = 1'b1;
            repeat (4) @(negedge clk);
            seen[W-1-k] = sdo_out;
            prev = sdo_out;
            if (k == W-1)
                chk(rx_valid == 1'b1, "R3 strobe on last bit", W'(rx_valid), W'(1));
            else if (k >= W-3)
                chk(rx_valid == 1'b0, "R3 no early strobe", W'(rx_valid), W'(0));
        end
        sclk_in = 1'b0;
        @(negedge clk);
        if (nbits == W)
            chk(rx_valid == 1'b0, "R3 strobe one cycle", W'(rx_valid), W'(0));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    initial begin : main
        logic [W-1:0] seen;
        logic [W-1:0] exp_tx;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R8: reset state
        chk(rx_valid == 1'b0, "R8 reset rx_valid", W'(rx_valid), W'(0));
        chk(sdo_out == 1'b0, "R8 reset sdo_out", W'(sdo_out), W'(0));

        // table walk: R2 receive, R5 response, R6 not-ready, R9 back to back
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][2*W]) load_resp(VEC[i][2*W-1:W]);
            exp_tx = VEC[i][2*W] ? VEC[i][2*W-1:W] : NRDY;
            send_bits(VEC[i][W-1:0], W, seen);
            chk(rx_word == VEC[i][W-1:0], "R2/R9 rx_word", rx_word, VEC[i][W-1:0]);
            chk(seen == exp_tx, "R5/R6 sdo frame", seen, exp_tx);
        end

        // R1: one-cycle glitch on the serial clock is ignored
        @(negedge clk);
        sclk_in = 1'b1;
        @(negedge clk);
        sclk_in = 1'b0;
        repeat (6) @(negedge clk);
        chk(sdo_out == 1'b0, "R1 glitch moved sdo", W'(sdo_out), W'(0));
        send_bits(17'h12345, W, seen);
        chk(rx_word == 17'h12345, "R1 glitch ignored", rx_word, 17'h12345);
        chk(seen == NRDY, "R1 glitch frame", seen, NRDY);

        // R7: second load replaces the first; R6: next packet reverts
        load_resp(17'h0AAAA);
        load_resp(17'h13C3C);
        send_bits(17'h00F0F, W, seen);
        chk(seen == 17'h13C3C, "R7 last load wins", seen, 17'h13C3C);
        send_bits(17'h1F0F0, W, seen);
        chk(seen == NRDY, "R6 reverts to not-ready", seen, NRDY);
        chk(rx_word == 17'h1F0F0, "R9 second packet", rx_word, 17'h1F0F0);

        // R8: reset mid-packet drops partial bits and the waiting response
        load_resp(17'h05A5A);
        send_bits(17'h1FFFF, 5, seen);
        do_reset();
        chk(sdo_out == 1'b0, "R8 sdo after reset", W'(sdo_out), W'(0));
        chk(rx_valid == 1'b0, "R8 rx_valid after reset", W'(rx_valid), W'(0));
        send_bits(17'h0C3C3, W, seen);
        chk(rx_word == 17'h0C3C3, "R8 count restarted", rx_word, 17'h0C3C3);
        chk(seen == NRDY, "R8 response dropped", seen, NRDY);

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=0", 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule